// File: doc/BRIEF.md
# Three-Wire Serial Memory Read Slave

This block is the device side of a three-wire serial memory. It has a chip select, a serial clock, a data input and a data output. A host raises chip select and clocks in a command one bit per rising serial-clock edge. The command is a start bit of 1, a two-bit opcode and a word or byte address. A word-size input selects 16-bit words or 8-bit bytes, and the address field is one bit longer in byte mode.

A read command drives one 0 bit first and then the addressed data, most significant bit first. The block then keeps streaming the following locations. The address wraps at the end of the array, and streaming ends only when chip select drops. Every other opcode is taken in and discarded, and data out stays high. The storage is a small register file with a synchronous backdoor write port, which is used for preloading.

Everything runs on a fast system clock. The serial clock, chip select and data in are treated as slow, already synchronous levels. A rising serial-clock edge is found by comparing the serial clock with a registered copy of itself. The serial clock may pause at either level for any time.

Top module: `mw_read_mem`

## Requirements
- R1: While idle with chip select high, data-in bits of 0 taken on serial-clock rises are ignored. The first 1 is the start bit.
- R2: Only the opcode 2'b10 (first bit after the start bit is the MSB) starts a read. After any other opcode, data out stays 1 until chip select falls.
- R3: The address field is AW bits when org=1 (16-bit words) and AW+1 bits when org=0 (bytes), MSB first.
- R4: The serial-clock rise that takes in the last address bit drives data out to 0. This 0 is the dummy bit.
- R5: Each following rise drives one data bit, MSB first. In byte mode, byte address b maps to word b>>1: even b is bits 15:8 and odd b is bits 7:0.
- R6: After the last bit of a location, the next rise drives the MSB of the next higher address with no gap. The address wraps from the top of the array to 0.
- R7: When chip select is low, the block returns to idle and data out is 1 from the next system clock.
- R8: Data out changes only on a serial-clock rise while chip select is high. A paused serial clock holds all state.
- R9: After reset, and whenever no read stream is active, data out is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| org | input | 1 | 1 = 16-bit words, 0 = 8-bit bytes |
| bd_we | input | 1 | Backdoor write enable |
| bd_addr | input | AW | Backdoor word address |
| bd_wdata | input | 16 | Backdoor write data |
| dout | output | 1 | Serial data out |

## Verification
A serial-clock rise is seen one system clock after it appears, and data out takes its new value on that same edge. A chip-select drop forces data out high one system clock later. The bench holds each serial-clock phase for three system clocks. It reads data out at the third falling edge after each rise, and it checks the high level three clocks after chip select drops, so every result has settled before it is sampled. During a long pause the bench compares data out with the value it held before the pause, before the next rise.

// File: rtl/mw_read_mem.sv
module mw_read_mem #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          sk,
  input  logic          di,
  input  logic          org,
  input  logic          bd_we,
  input  logic [AW-1:0] bd_addr,
  input  logic [15:0]   bd_wdata,
  output logic          dout
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(AW + 18);

  typedef enum logic [2:0] {S_IDLE, S_OP, S_ADDR, S_STREAM, S_SKIP} st_t;

  logic [15:0] mem [DEPTH];
  st_t         state;
  logic        sk_q;
  logic [1:0]  op;
  logic [AW:0] addr;
  logic [CW-1:0] cnt;
  logic [15:0] shreg;

  always_ff @(posedge clk)
    if (bd_we) mem[bd_addr] <= bd_wdata;

  wire            rise    = cs & sk & ~sk_q;
  wire [CW-1:0]   alen_m1 = org ? CW'(AW - 1) : CW'(AW);
  wire [CW-1:0]   wlen_m1 = org ? CW'(15) : CW'(7);
  wire [AW:0]     addr_in = {addr[AW-1:0], di};
  wire [AW:0]     nxt     = addr + 1'b1;
  wire [AW:0]     sel     = (state == S_ADDR) ? addr_in : nxt;
  wire [15:0]     wsel    = org ? mem[sel[AW-1:0]] : mem[sel[AW:1]];
  wire [15:0]     load    = org ? wsel : {(sel[0] ? wsel[7:0] : wsel[15:8]), 8'h00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sk_q  <= 1'b0;
      op    <= '0;
      addr  <= '0;
      cnt   <= '0;
      shreg <= '0;
      dout  <= 1'b1;
    end else begin
      sk_q <= sk;
      if (!cs) begin
        state <= S_IDLE;
        dout  <= 1'b1;
      end else if (rise) begin
        case (state)
          S_IDLE: if (di) begin
            state <= S_OP;
            cnt   <= '0;
          end
          S_OP: begin
            op  <= {op[0], di};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(1)) begin
              state <= S_ADDR;
              cnt   <= '0;
            end
          end
          S_ADDR: begin
            addr <= addr_in;
            cnt  <= cnt + 1'b1;
            if (cnt == alen_m1) begin
              cnt <= '0;
              if (op == 2'b10) begin
                state <= S_STREAM;
                shreg <= load;
                dout  <= 1'b0;
              end else begin
                state <= S_SKIP;
              end
            end
          end
          S_STREAM: begin
            dout  <= shreg[15];
            shreg <= {shreg[14:0], 1'b0};
            cnt   <= cnt + 1'b1;
            if (cnt == wlen_m1) begin
              cnt   <= '0;
              addr  <= nxt;
              shreg <= load;
            end
          end
          default: dout <= 1'b1;
        endcase
      end
    end
  end
endmodule

module mw_read_mem_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          sk,
  input logic          sk_q,
  input logic          org,
  input logic [2:0]    state,
  input logic [CW-1:0] cnt,
  input logic          dout
);
  assert_cs_low_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (dout && state == 3'd0));

  assert_hold_no_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !(sk && !sk_q)) |=> $stable(dout));

  assert_skip_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4) |-> dout);

  assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0) |-> dout);

  assert_bit_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd3) |-> (cnt <= (org ? CW'(15) : CW'(7))));
endmodule

bind mw_read_mem mw_read_mem_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .sk_q(sk_q), .org(org),
  .state(state), .cnt(cnt), .dout(dout)
);

// File: tb/mw_read_mem_tb.sv
module mw_read_mem_tb;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic bd_we = 1'b0;
  logic [AW-1:0] bd_addr = '0;
  logic [15:0] bd_wdata = '0;
  logic dout;
  logic [15:0] ref_mem [DEPTH];
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mw_read_mem #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
    .bd_we(bd_we), .bd_addr(bd_addr), .bd_wdata(bd_wdata), .dout(dout)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic logic [15:0] exp_word(int a, bit o);
    logic [15:0] w;
    if (o) return ref_mem[a % DEPTH];
    w = ref_mem[(a % (2*DEPTH)) >> 1];
    return (a % 2) ? {8'h00, w[7:0]} : {8'h00, w[15:8]};
  endfunction

  task automatic bit_cycle(input logic d, output logic q);
    @(negedge clk); di = d; sk = 1'b0;
    repeat (3) @(negedge clk);
    sk = 1'b1;
    repeat (3) @(negedge clk);
    q = dout;
    sk = 1'b0;
  endtask

  task automatic send_cmd(input logic [1:0] op, input int a, input bit o,
                          input int lead, output logic q);
    int alen;
    alen = o ? AW : AW + 1;
    @(negedge clk); org = o; cs = 1'b1;
    for (int i = 0; i < lead; i++) bit_cycle(1'b0, q);
    bit_cycle(1'b1, q);
    bit_cycle(op[1], q);
    bit_cycle(op[0], q);
    for (int i = alen - 1; i >= 0; i--) bit_cycle(a[i], q);
  endtask

  task automatic read_word(input bit o, output logic [15:0] v);
    logic q;
    v = '0;
    for (int i = 0; i < (o ? 16 : 8); i++) begin
      bit_cycle($urandom_range(0, 1), q);
      v = {v[14:0], q};
    end
  endtask

  task automatic drop_cs();
    @(negedge clk); cs = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 idle high after cs drop", {15'd0, dout}, 16'd1);
  endtask

  task automatic do_read(input int a, input bit o, input int lead, input int n);
    logic q;
    logic [15:0] v;
    int lim;
    lim = o ? DEPTH : 2 * DEPTH;
    send_cmd(2'b10, a, o, lead, q);
    check("R4 dummy zero", {15'd0, q}, 16'd0);
    for (int k = 0; k < n; k++) begin
      read_word(o, v);
      check(k == 0 ? "R5 first word" : "R6 sequential word", v, exp_word((a + k) % lim, o));
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic q;
    logic [15:0] v;
    logic [15:0] held;
    bit allhigh;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R9 reset dout", {15'd0, dout}, 16'd1);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      bd_we = 1'b1; bd_addr = AW'(i); bd_wdata = 16'($urandom);
      ref_mem[i] = bd_wdata;
    end
    @(negedge clk); bd_we = 1'b0;

    // R1 R3 R5: word read at address 0, no leading zeros, then three leading zeros
    do_read(0, 1'b1, 0, 1); drop_cs();
    do_read(5, 1'b1, 3, 2); drop_cs();
    // R6: wrap at top of the word array and of the byte space
    do_read(DEPTH - 1, 1'b1, 0, 3); drop_cs();
    do_read(2 * DEPTH - 2, 1'b0, 1, 4); drop_cs();
    // R5: odd and even bytes
    do_read(9, 1'b0, 0, 2); drop_cs();

    // R2: non-read opcodes leave dout high
    for (int op = 0; op < 4; op++) begin
      if (op == 2) continue;
      send_cmd(2'(op), 3, op[0], 0, q);
      allhigh = q;
      for (int i = 0; i < 20; i++) begin
        bit_cycle($urandom_range(0, 1), q);
        allhigh &= q;
      end
      check("R2 ignored opcode keeps dout high", {15'd0, allhigh}, 16'd1);
      drop_cs();
    end

    // R8: pause mid-word holds dout, then resumes correctly
    send_cmd(2'b10, 12, 1'b1, 0, q);
    v = '0;
    for (int i = 0; i < 5; i++) begin bit_cycle(1'b0, q); v = {v[14:0], q}; end
    held = {15'd0, dout};
    @(negedge clk); di = 1'b1;
    repeat (300) @(negedge clk);
    check("R8 dout held during pause", {15'd0, dout}, held);
    for (int i = 0; i < 11; i++) begin bit_cycle(1'b1, q); v = {v[14:0], q}; end
    check("R8 word after pause", v, exp_word(12, 1'b1));
    read_word(1'b1, v);
    check("R6 word after paused word", v, exp_word(13, 1'b1));
    // R7: cs drop mid-word then a fresh command works
    for (int i = 0; i < 4; i++) bit_cycle(1'b0, q);
    drop_cs();
    do_read(20, 1'b1, 0, 1); drop_cs();

    // random mix
    for (int t = 0; t < 24; t++) begin
      bit o;
      o = 1'($urandom_range(0, 1));
      do_read(int'($urandom_range(0, o ? DEPTH - 1 : 2 * DEPTH - 1)), o,
              int'($urandom_range(0, 3)), int'($urandom_range(1, 4)));
      drop_cs();
    end
    finish_run();
  end
endmodule